// File: doc/BRIEF.md
# Dirty-Line Flush Write Sizer

This block sits between a data cache and its memory port. It decides how much of a 32-byte line (eight 32-bit words) goes back to memory when the line is flushed. The dirty state arrives as one bit per doubleword, four bits for a line. The block picks the smallest aligned region that covers every dirty doubleword: nothing, one doubleword, one quadword half of the line, or the whole line. It then issues a single write command with a starting word, a word count and the selected words.

A mode input forces an all-or-nothing choice. When it is set, any dirty bit makes the whole line dirty, and a clean line still writes nothing. The command is held until the memory side accepts it. The block then waits for a separate memory acknowledge and reports completion one cycle later. A new flush request is accepted only when no earlier flush is in progress.

Top module: `fls_flush_sizer`

## Requirements
- R1: After reset, `req_ready` is 1, and `wr_valid` and `done` are 0.
- R2: In normal mode, when exactly one dirty bit `i` is set, the write has `wr_start` = 2*i and `wr_len` = 2. Dirty bit `i` covers line words 2*i and 2*i+1.
- R3: In normal mode, when two or more dirty bits are set and all lie in bits 1:0, the write has start 0 and length 4. When they all lie in bits 3:2, the write has start 4 and length 4.
- R4: In normal mode, when dirty bits are set in both bits 1:0 and bits 3:2, the write has start 0 and length 8.
- R5: When `force_full` is 1, any nonzero dirty vector gives start 0 and length 8, and a zero vector gives no write.
- R6: A request with no dirty bits set, in either mode, issues no write, and `done` is 1 in the cycle after acceptance.
- R7: `wr_valid` stays at 1, with `wr_start`, `wr_len` and `wr_data` unchanged, until a cycle in which `wr_ready` is 1.
- R8: `done` is a one-cycle pulse in the cycle after `mem_ack` is seen following an accepted write. A `mem_ack` before the write is accepted has no effect.
- R9: `req_ready` is 0 from acceptance until `done` has been given, and a `req_valid` in that time is ignored.
- R10: Line word j is `req_line[32*j +: 32]`. In `wr_data`, word k (bits `32*k +: 32`) carries line word `wr_start`+k for k < `wr_len`, and the words from `wr_len` upward are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Flush request |
| req_ready | output | 1 | Block is idle and takes a request |
| req_dirty | input | 4 | Dirty bit per doubleword of the line |
| req_line | input | 256 | Line data, word j at bits 32*j |
| force_full | input | 1 | All-or-nothing flush mode |
| wr_valid | output | 1 | Write command present |
| wr_ready | input | 1 | Memory accepts the command |
| wr_start | output | 3 | First line word written |
| wr_len | output | 4 | Number of words written (2, 4 or 8) |
| wr_data | output | 256 | Written words packed from word 0 |
| mem_ack | input | 1 | Memory completion acknowledge |
| done | output | 1 | Flush complete pulse |

## Verification
The hardest situation to reach is a stray acknowledge or a second request that arrives while a write is still waiting for `wr_ready`. A normal memory never produces either one. The stimulus therefore drives a repeat `req_valid` on the cycle after acceptance and a spurious `mem_ack` while the command is stalled, and it holds `wr_ready` low for several cycles. Every dirty pattern class is run in both modes, with the all-clear case included.

// File: rtl/fls_pkg.sv
package fls_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_SEND = 2'd1,
      ST_WAIT = 2'd2,
      ST_DONE = 2'd3
   } fls_state_e;

   typedef enum logic [1:0] {
      SZ_NONE = 2'd0,
      SZ_GRAN = 2'd1,
      SZ_HALF = 2'd2,
      SZ_LINE = 2'd3
   } fls_size_e;
endpackage

// File: rtl/fls_size_dec.sv
module fls_size_dec
   import fls_pkg::*;
#(
   parameter int LINE_WORDS = 8,
   parameter int GRAN_WORDS = 2,
   localparam int NGRAN = LINE_WORDS / GRAN_WORDS,
   localparam int HALF  = NGRAN / 2,
   localparam int SW    = $clog2(LINE_WORDS),
   localparam int LW    = SW + 1
) (
   input  logic [NGRAN-1:0] dirty,
   input  logic             force_full,
   output fls_size_e        size,
   output logic [SW-1:0]    start,
   output logic [LW-1:0]    len,
   output logic             any
);
   logic [NGRAN-1:0] eff;
   logic [SW:0]      cnt;
   logic [SW-1:0]    first;
   logic             lo_only, hi_only;

   always_comb begin
      eff = force_full ? {NGRAN{|dirty}} : dirty;
      cnt = '0;
      first = '0;
      for (int i = NGRAN - 1; i >= 0; i--) begin
         if (eff[i]) begin
            cnt   = cnt + 1'b1;
            first = SW'(i * GRAN_WORDS);
         end
      end
      lo_only = ~|eff[NGRAN-1:HALF];
      hi_only = ~|eff[HALF-1:0];
      any     = |eff;
   end

   always_comb begin
      size  = SZ_NONE;
      start = '0;
      len   = '0;
      if (!any) begin
         size = SZ_NONE;
      end else if (cnt == 1) begin
         size  = SZ_GRAN;
         start = first;
         len   = LW'(GRAN_WORDS);
      end else if (lo_only || hi_only) begin
         size  = SZ_HALF;
         start = hi_only ? SW'(LINE_WORDS / 2) : '0;
         len   = LW'(LINE_WORDS / 2);
      end else begin
         size  = SZ_LINE;
         len   = LW'(LINE_WORDS);
      end
   end
endmodule

// File: rtl/fls_align.sv
module fls_align #(
   parameter int WORD_W     = 32,
   parameter int LINE_WORDS = 8,
   parameter bit PACK_LOW   = 1'b1,
   localparam int LINE_BITS = WORD_W * LINE_WORDS,
   localparam int SW        = $clog2(LINE_WORDS),
   localparam int LW        = SW + 1
) (
   input  logic [LINE_BITS-1:0] line,
   input  logic [SW-1:0]        start,
   input  logic [LW-1:0]        len,
   output logic [LINE_BITS-1:0] data
);
   generate
      if (PACK_LOW) begin : g_pack
         always_comb begin
            data = '0;
            for (int k = 0; k < LINE_WORDS; k++) begin
               if (k < int'(len) && (int'(start) + k) < LINE_WORDS)
                  data[k*WORD_W +: WORD_W] = line[(int'(start) + k)*WORD_W +: WORD_W];
            end
         end
      end else begin : g_inplace
         always_comb begin
            data = '0;
            for (int k = 0; k < LINE_WORDS; k++) begin
               if (k >= int'(start) && k < int'(start) + int'(len))
                  data[k*WORD_W +: WORD_W] = line[k*WORD_W +: WORD_W];
            end
         end
      end
   endgenerate
endmodule

// File: rtl/fls_ctrl.sv
module fls_ctrl
   import fls_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_valid,
   input  logic       has_write,
   input  logic       wr_ready,
   input  logic       mem_ack,
   output logic       accept,
   output fls_state_e state
);
   fls_state_e nxt;

   assign accept = req_valid && (state == ST_IDLE);

   always_comb begin
      nxt = state;
      unique case (state)
         ST_IDLE: if (accept) nxt = has_write ? ST_SEND : ST_DONE;
         ST_SEND: if (wr_ready) nxt = ST_WAIT;
         ST_WAIT: if (mem_ack) nxt = ST_DONE;
         ST_DONE: nxt = ST_IDLE;
         default: nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= nxt;
   end
endmodule

// File: rtl/fls_flush_sizer.sv
module fls_flush_sizer
   import fls_pkg::*;
#(
   parameter int WORD_W     = 32,
   parameter int LINE_WORDS = 8,
   parameter int GRAN_WORDS = 2,
   parameter bit PACK_LOW   = 1'b1,
   localparam int NGRAN     = LINE_WORDS / GRAN_WORDS,
   localparam int LINE_BITS = WORD_W * LINE_WORDS,
   localparam int SW        = $clog2(LINE_WORDS),
   localparam int LW        = SW + 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   output logic                 req_ready,
   input  logic [NGRAN-1:0]     req_dirty,
   input  logic [LINE_BITS-1:0] req_line,
   input  logic                 force_full,
   output logic                 wr_valid,
   input  logic                 wr_ready,
   output logic [SW-1:0]        wr_start,
   output logic [LW-1:0]        wr_len,
   output logic [LINE_BITS-1:0] wr_data,
   input  logic                 mem_ack,
   output logic                 done
);
   initial begin
      if (WORD_W < 1) $error("WORD_W must be positive");
      if (LINE_WORDS < 4 || (LINE_WORDS & (LINE_WORDS - 1)) != 0)
         $error("LINE_WORDS must be a power of two of at least 4");
      if (GRAN_WORDS < 1 || (LINE_WORDS % GRAN_WORDS) != 0)
         $error("GRAN_WORDS must divide LINE_WORDS");
      if (NGRAN < 2 || (NGRAN & (NGRAN - 1)) != 0)
         $error("granule count must be a power of two of at least 2");
   end

   fls_size_e            dec_size;
   logic [SW-1:0]        dec_start;
   logic [LW-1:0]        dec_len;
   logic                 dec_any;
   logic [LINE_BITS-1:0] aligned;
   logic                 accept;
   fls_state_e           state;

   fls_size_dec #(.LINE_WORDS(LINE_WORDS), .GRAN_WORDS(GRAN_WORDS)) u_dec (
      .dirty(req_dirty), .force_full(force_full),
      .size(dec_size), .start(dec_start), .len(dec_len), .any(dec_any)
   );

   fls_align #(.WORD_W(WORD_W), .LINE_WORDS(LINE_WORDS), .PACK_LOW(PACK_LOW)) u_align (
      .line(req_line), .start(dec_start), .len(dec_len), .data(aligned)
   );

   fls_ctrl u_ctrl (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .has_write(dec_size != SZ_NONE),
      .wr_ready(wr_ready), .mem_ack(mem_ack), .accept(accept), .state(state)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_start <= '0;
         wr_len   <= '0;
         wr_data  <= '0;
      end else if (accept && dec_any) begin
         wr_start <= dec_start;
         wr_len   <= dec_len;
         wr_data  <= aligned;
      end
   end

   assign req_ready = (state == ST_IDLE);
   assign wr_valid  = (state == ST_SEND);
   assign done      = (state == ST_DONE);
endmodule

// File: rtl/fls_chk.sv
module fls_chk #(
   parameter int WORD_W     = 32,
   parameter int LINE_WORDS = 8,
   parameter int GRAN_WORDS = 2,
   localparam int NGRAN     = LINE_WORDS / GRAN_WORDS,
   localparam int LINE_BITS = WORD_W * LINE_WORDS,
   localparam int SW        = $clog2(LINE_WORDS),
   localparam int LW        = SW + 1
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 req_valid,
   input logic                 req_ready,
   input logic [NGRAN-1:0]     req_dirty,
   input logic [LINE_BITS-1:0] req_line,
   input logic                 force_full,
   input logic                 wr_valid,
   input logic                 wr_ready,
   input logic [SW-1:0]        wr_start,
   input logic [LW-1:0]        wr_len,
   input logic [LINE_BITS-1:0] wr_data,
   input logic                 mem_ack,
   input logic                 done
);
   logic pend;
   always_ff @(posedge clk) begin
      if (!rst_n)                   pend <= 1'b0;
      else if (wr_valid && wr_ready) pend <= 1'b1;
      else if (pend && mem_ack)      pend <= 1'b0;
   end

   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid && !wr_ready |=> wr_valid && $stable(wr_start) && $stable(wr_len) && $stable(wr_data));

   p_legal_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> (wr_len == LW'(GRAN_WORDS) || wr_len == LW'(LINE_WORDS / 2) || wr_len == LW'(LINE_WORDS))
                   && ((LW'(wr_start) & (wr_len - 1'b1)) == '0));

   p_force_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready && force_full && (|req_dirty) |=> wr_valid && wr_start == '0 && wr_len == LW'(LINE_WORDS));

   p_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready && (req_dirty == '0) |=> done && !wr_valid);

   p_done_after_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
      pend && mem_ack |=> done);

   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid || pend) |-> !req_ready);
endmodule

bind fls_flush_sizer fls_chk #(
   .WORD_W(WORD_W), .LINE_WORDS(LINE_WORDS), .GRAN_WORDS(GRAN_WORDS)
) u_chk (.*);

// File: tb/sim_fls_flush_sizer.sv
module sim_fls_flush_sizer;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         req_valid = 1'b0;
   logic         req_ready;
   logic [3:0]   req_dirty = '0;
   logic [255:0] req_line = '0;
   logic         force_full = 1'b0;
   logic         wr_valid;
   logic         wr_ready = 1'b0;
   logic [2:0]   wr_start;
   logic [3:0]   wr_len;
   logic [255:0] wr_data;
   logic         mem_ack = 1'b0;
   logic         done;

   int total = 0;
   int bad = 0;
   int cycles = 0;
   bit running = 1'b0;
   string tag = "R1";

   always #10 clk = ~clk;

   fls_flush_sizer u0 (.*);

   // reference model
   int           m_phase = 0;
   int           m_start = 0;
   int           m_len = 0;
   logic [255:0] m_data = '0;

   task automatic model_calc(input logic [3:0] d, input logic f, input logic [255:0] ln,
                             output int st, output int ln_w, output logic [255:0] dat);
      int idx[$];
      dat = '0;
      st = 0;
      ln_w = 0;
      for (int i = 0; i < 4; i++) if (d[i]) idx.push_back(i);
      if (f && idx.size() > 0) begin
         st = 0; ln_w = 8;
      end else if (idx.size() == 1) begin
         st = idx[0] * 2; ln_w = 2;
      end else if (idx.size() > 1) begin
         if (idx[idx.size()-1] < 2)  begin st = 0; ln_w = 4; end
         else if (idx[0] >= 2)       begin st = 4; ln_w = 4; end
         else                        begin st = 0; ln_w = 8; end
      end
      for (int k = 0; k < ln_w; k++) dat[k*32 +: 32] = ln[(st+k)*32 +: 32];
   endtask

   always @(posedge clk) begin
      int s, l;
      logic [255:0] dd;
      if (!rst_n) m_phase <= 0;
      else case (m_phase)
         0: if (req_valid) begin
               model_calc(req_dirty, force_full, req_line, s, l, dd);
               m_start <= s; m_len <= l; m_data <= dd;
               m_phase <= (l > 0) ? 1 : 3;
            end
         1: if (wr_ready) m_phase <= 2;
         2: if (mem_ack) m_phase <= 3;
         default: m_phase <= 0;
      endcase
   end

   task automatic check(input string req, input string what, input logic [255:0] act, input logic [255:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // compare on every clock, away from the active edge
   always @(negedge clk) begin
      if (rst_n && running) begin
         check("R9", "req_ready", 256'(req_ready), 256'(m_phase == 0));
         check("R7", "wr_valid", 256'(wr_valid), 256'(m_phase == 1));
         check("R8", "done", 256'(done), 256'(m_phase == 3));
         if (m_phase == 1) begin
            check(tag, "wr_start", 256'(wr_start), 256'(m_start));
            check(tag, "wr_len", 256'(wr_len), 256'(m_len));
            check("R10", "wr_data", wr_data, m_data);
         end
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         bad++;
         total++;
         $display("FAIL watchdog expired actual=%0d expected<=100000", cycles);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic flush(input logic [3:0] d, input logic f, input int rdly, input int adly, input string t);
      @(negedge clk);
      tag = t;
      req_valid = 1'b1;
      req_dirty = d;
      force_full = f;
      for (int j = 0; j < 8; j++) req_line[j*32 +: 32] = $urandom();
      @(negedge clk);
      req_dirty = ~d;            // R9: request while busy is ignored
      force_full = ~f;
      @(negedge clk);
      req_valid = 1'b0;
      mem_ack = 1'b1;            // R8: early ack has no effect
      @(negedge clk);
      mem_ack = 1'b0;
      if (m_phase == 1) begin
         repeat (rdly) @(negedge clk);
         wr_ready = 1'b1;
         @(negedge clk);
         wr_ready = 1'b0;
         repeat (adly) @(negedge clk);
         mem_ack = 1'b1;
         @(negedge clk);
         mem_ack = 1'b0;
      end
      repeat (2) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "reset req_ready", 256'(req_ready), 256'(1));
      check("R1", "reset wr_valid", 256'(wr_valid), 256'(0));
      check("R1", "reset done", 256'(done), 256'(0));
      running = 1'b1;
      for (int i = 0; i < 4; i++) flush(4'b0001 << i, 1'b0, i, 1, "R2");
      flush(4'b0011, 1'b0, 0, 0, "R3");
      flush(4'b1100, 1'b0, 3, 2, "R3");
      flush(4'b0101, 1'b0, 1, 0, "R4");
      flush(4'b1001, 1'b0, 0, 3, "R4");
      flush(4'b1111, 1'b0, 2, 1, "R4");
      flush(4'b0001, 1'b1, 1, 1, "R5");
      flush(4'b1000, 1'b1, 4, 0, "R5");
      flush(4'b0000, 1'b1, 0, 0, "R5");
      flush(4'b0000, 1'b0, 0, 0, "R6");
      flush(4'b0110, 1'b0, 2, 2, "R4");
      flush(4'b0100, 1'b0, 5, 0, "R2");
      running = 1'b0;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule